// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block decodes the floating-point group of a 16-bit instruction encoding. On every clock it looks at one opcode together with the precision and bank bits of its own floating-point control word. One cycle later it presents the operation, the precision, the physical source and destination indices into a 32-entry single-precision register file, the write enables for the register file and for the integer transfer register, an immediate for the constant loads, and an illegal-instruction flag. The arithmetic datapath and the register file sit downstream.

The control word is held inside the block. Writes keep only the low 22 bits. Bit 0 drives a rounding-mode select: 1 chooses round toward zero and 0 chooses round to nearest even. Bit 19 switches the decoder to double precision. In that mode a register pair is named by an even index, and an odd index is illegal. Bit 21 moves every register index into the upper half of the file by XOR with 0x10.

Top module: `fpu_op_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the control word reads 0x00040001, `rnd_zero_o` is 1, and every decode output is 0. Reset is asynchronous and active low; the block leaves reset two rising edges after `rst_n` goes high.
- R2: A control write stores `ctl_wdata_i & 0x003FFFFF`, visible on `ctl_q_o` after the next rising edge. Bits 31:22 always read 0.
- R3: `rnd_zero_o` equals bit 0 of the control word.
- R4: Opcodes with `insn & 0xF00F` equal to 0xF000, 0xF001, 0xF002 or 0xF003 decode one cycle later as add (op 1), subtract (2), multiply (3) or divide (4). For these, the first source and the destination come from bits 11:8 and the second source comes from bits 7:4. The register write enable is 1.
- R5: The physical index is `{1'b0, field} ^ 0x10` when bit 21 of the control word is 1, and the field unchanged otherwise.
- R6: When bit 19 is 1, a valid decode has `dec_dbl_o` = 1. A two-operand opcode with bit 8 or bit 4 set is illegal in that mode.
- R7: For `insn & 0xF0FF` = 0xF02D, the decoder emits integer-to-float (op 5) with the destination from bits 11:8 and the register write enabled. For 0xF03D it emits truncate-to-integer (op 6) with the first source from bits 11:8 and the transfer-register write enabled. In double mode, either one with bit 8 set is illegal.
- R8: Low byte 0x8D loads constant 0 (op 7, immediate 0x00000000) and low byte 0x9D loads constant 1 (op 8, immediate 0x3F800000), with the register write enabled and the destination from bits 11:8. Both are illegal when bit 19 is 1.
- R9: An opcode with top nibble 0xF that matches none of these patterns raises `dec_illegal_o`. On an illegal decode, op is 0 and both write enables are 0. An opcode with any other top nibble gives op 0 and no illegal flag.
- R10: The mode bits are sampled in the same cycle as the opcode. A control write in one cycle affects the opcode of the next cycle and not the opcode of the same cycle.
- R11: Index outputs that an operation does not use read 0, as do `dec_dbl_o` and the immediate when they do not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 16 | Opcode decoded this cycle |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| ctl_q_o | output | 32 | Current control word |
| rnd_zero_o | output | 1 | 1 = round toward zero, 0 = nearest even |
| dec_op_o | output | 4 | Operation code (0 none, 1..8 as in R4, R7, R8) |
| dec_dbl_o | output | 1 | Double-precision operation |
| dec_src_a_o | output | 5 | First source physical index |
| dec_src_b_o | output | 5 | Second source physical index |
| dec_dst_o | output | 5 | Destination physical index |
| dec_fr_we_o | output | 1 | Register file write enable |
| dec_ful_we_o | output | 1 | Transfer register write enable |
| dec_illegal_o | output | 1 | Illegal instruction |
| dec_imm_o | output | 32 | Constant for load-constant operations |

## Verification
Random opcodes are weighted toward the group's top nibble. They mix exact two-operand, convert and constant patterns with arbitrary low bytes, so legal decodes are tested alongside unmatched codes. Random control writes flip the precision and bank bits during the run. This separates the single and double rules, the two halves of the register file, and the odd-index screening. Directed cases cover each odd-bit position in double mode, the constant loads in double mode, a write of all ones to the control word, and a mode change written in the same cycle as a dependent opcode, which shows that the mode is sampled with the opcode.

// File: rtl/fpu_dec_pkg.sv
package fpu_dec_pkg;
  localparam int INSN_W    = 16;
  localparam int FLD_W     = 4;
  localparam int RF_IDX_W  = FLD_W + 1;
  localparam int CTL_W     = 32;
  localparam int IMM_W     = 32;

  localparam logic [IMM_W-1:0] IMM_ONE = 32'h3F80_0000;

  typedef enum logic [3:0] {
    FOP_NONE = 4'd0,
    FOP_ADD  = 4'd1,
    FOP_SUB  = 4'd2,
    FOP_MUL  = 4'd3,
    FOP_DIV  = 4'd4,
    FOP_ITOF = 4'd5,
    FOP_FTOI = 4'd6,
    FOP_LD0  = 4'd7,
    FOP_LD1  = 4'd8
  } fop_e;

  typedef struct packed {
    fop_e                op;
    logic                dbl;
    logic [RF_IDX_W-1:0] src_a;
    logic [RF_IDX_W-1:0] src_b;
    logic [RF_IDX_W-1:0] dst;
    logic                fr_we;
    logic                ful_we;
    logic                illegal;
    logic [IMM_W-1:0]    imm;
  } fdec_t;
endpackage

// File: rtl/fpu_ctl_reg.sv
module fpu_ctl_reg #(
  parameter int               W       = 32,
  parameter logic [W-1:0]     WR_MASK = 32'h003F_FFFF,
  parameter logic [W-1:0]     RST_VAL = 32'h0004_0001,
  parameter int               RND_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         rnd_zero_o
);
  logic [W-1:0] ctl_q, ctl_d;
  logic         ctl_en;

  assign ctl_en = wr_i;

  always_comb begin
    ctl_d = wdata_i & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign q_o        = ctl_q;
  assign rnd_zero_o = ctl_q[RND_BIT];
endmodule

// File: rtl/fpu_bank_map.sv
module fpu_bank_map
  import fpu_dec_pkg::*;
(
  input  logic [FLD_W-1:0]    field_i,
  input  logic                bank_i,
  output logic [RF_IDX_W-1:0] idx_o
);
  localparam logic [RF_IDX_W-1:0] BANK_FLIP = RF_IDX_W'(1) << FLD_W;

  always_comb begin
    idx_o = {1'b0, field_i} ^ (bank_i ? BANK_FLIP : '0);
  end
endmodule

// File: rtl/fpu_op_classify.sv
module fpu_op_classify
  import fpu_dec_pkg::*;
(
  input  logic [3:0]          grp_i,
  input  logic [7:0]          low_i,
  input  logic                b8_i,
  input  logic                dbl_i,
  input  logic [RF_IDX_W-1:0] idx_n_i,
  input  logic [RF_IDX_W-1:0] idx_m_i,
  output fdec_t               dec_o
);
  logic is_grp, is_two, two_odd;

  assign is_grp  = (grp_i == 4'hF);
  assign is_two  = (low_i[3:2] == 2'b00);
  assign two_odd = b8_i | low_i[4];

  always_comb begin
    dec_o = '0;
    if (is_grp) begin
      if (is_two) begin
        if (dbl_i && two_odd) begin
          dec_o.illegal = 1'b1;
        end else begin
          unique case (low_i[1:0])
            2'd0:    dec_o.op = FOP_ADD;
            2'd1:    dec_o.op = FOP_SUB;
            2'd2:    dec_o.op = FOP_MUL;
            default: dec_o.op = FOP_DIV;
          endcase
          dec_o.dbl   = dbl_i;
          dec_o.src_a = idx_n_i;
          dec_o.src_b = idx_m_i;
          dec_o.dst   = idx_n_i;
          dec_o.fr_we = 1'b1;
        end
      end else begin
        unique case (low_i)
          8'h2D: begin
            if (dbl_i && b8_i) dec_o.illegal = 1'b1;
            else begin
              dec_o.op    = FOP_ITOF;
              dec_o.dbl   = dbl_i;
              dec_o.dst   = idx_n_i;
              dec_o.fr_we = 1'b1;
            end
          end
          8'h3D: begin
            if (dbl_i && b8_i) dec_o.illegal = 1'b1;
            else begin
              dec_o.op     = FOP_FTOI;
              dec_o.dbl    = dbl_i;
              dec_o.src_a  = idx_n_i;
              dec_o.ful_we = 1'b1;
            end
          end
          8'h8D, 8'h9D: begin
            if (dbl_i) dec_o.illegal = 1'b1;
            else begin
              dec_o.op    = low_i[4] ? FOP_LD1 : FOP_LD0;
              dec_o.imm   = low_i[4] ? IMM_ONE : '0;
              dec_o.dst   = idx_n_i;
              dec_o.fr_we = 1'b1;
            end
          end
          default: dec_o.illegal = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpu_op_decoder.sv
module fpu_op_decoder
  import fpu_dec_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_MASK = 32'h003F_FFFF,
  parameter logic [CTL_W-1:0] CTL_RST  = 32'h0004_0001,
  parameter int               RND_BIT  = 0,
  parameter int               PREC_BIT = 19,
  parameter int               BANK_BIT = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSN_W-1:0]   insn_i,
  input  logic                ctl_wr_i,
  input  logic [CTL_W-1:0]    ctl_wdata_i,
  output logic [CTL_W-1:0]    ctl_q_o,
  output logic                rnd_zero_o,
  output logic [3:0]          dec_op_o,
  output logic                dec_dbl_o,
  output logic [RF_IDX_W-1:0] dec_src_a_o,
  output logic [RF_IDX_W-1:0] dec_src_b_o,
  output logic [RF_IDX_W-1:0] dec_dst_o,
  output logic                dec_fr_we_o,
  output logic                dec_ful_we_o,
  output logic                dec_illegal_o,
  output logic [IMM_W-1:0]    dec_imm_o
);
  localparam int NFLD = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_run_n = rst_sync_q[1];

  fpu_ctl_reg #(
    .W(CTL_W), .WR_MASK(CTL_MASK), .RST_VAL(CTL_RST), .RND_BIT(RND_BIT)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_run_n),
    .wr_i      (ctl_wr_i),
    .wdata_i   (ctl_wdata_i),
    .q_o       (ctl_q_o),
    .rnd_zero_o(rnd_zero_o)
  );

  // register fields: [1] = bits 11:8, [0] = bits 7:4
  logic [NFLD-1:0][FLD_W-1:0]    fld;
  logic [NFLD-1:0][RF_IDX_W-1:0] idx;

  assign fld = {insn_i[11:8], insn_i[7:4]};

  for (genvar g = 0; g < NFLD; g++) begin : g_map
    fpu_bank_map u_map (
      .field_i(fld[g]),
      .bank_i (ctl_q_o[BANK_BIT]),
      .idx_o  (idx[g])
    );
  end

  fdec_t dec_d, dec_q;
  logic  dec_en;

  fpu_op_classify u_cls (
    .grp_i  (insn_i[15:12]),
    .low_i  (insn_i[7:0]),
    .b8_i   (insn_i[8]),
    .dbl_i  (ctl_q_o[PREC_BIT]),
    .idx_n_i(idx[1]),
    .idx_m_i(idx[0]),
    .dec_o  (dec_d)
  );

  assign dec_en = 1'b1;

  always_ff @(posedge clk or negedge rst_run_n) begin
    if (!rst_run_n)  dec_q <= '0;
    else if (dec_en) dec_q <= dec_d;
  end

  assign dec_op_o      = dec_q.op;
  assign dec_dbl_o     = dec_q.dbl;
  assign dec_src_a_o   = dec_q.src_a;
  assign dec_src_b_o   = dec_q.src_b;
  assign dec_dst_o     = dec_q.dst;
  assign dec_fr_we_o   = dec_q.fr_we;
  assign dec_ful_we_o  = dec_q.ful_we;
  assign dec_illegal_o = dec_q.illegal;
  assign dec_imm_o     = dec_q.imm;
endmodule

// File: rtl/fpu_op_decoder_chk.sv
module fpu_op_decoder_chk #(
  parameter logic [31:0] CTL_MASK = 32'h003F_FFFF,
  parameter int          PREC_BIT = 19,
  parameter int          BANK_BIT = 21
) (
  input logic        clk,
  input logic        rst_run_n,
  input logic        ctl_wr_i,
  input logic [31:0] ctl_wdata_i,
  input logic [31:0] ctl_q_o,
  input logic        rnd_zero_o,
  input logic [3:0]  dec_op_o,
  input logic        dec_dbl_o,
  input logic [4:0]  dec_src_a_o,
  input logic [4:0]  dec_dst_o,
  input logic        dec_fr_we_o,
  input logic        dec_ful_we_o,
  input logic        dec_illegal_o,
  input logic [31:0] dec_imm_o
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_run_n)
    (ctl_q_o & ~CTL_MASK) == 32'h0);

  a_r2_write_kept: assert property (@(posedge clk) disable iff (!rst_run_n)
    $past(rst_run_n) && $past(ctl_wr_i) |-> ctl_q_o == ($past(ctl_wdata_i) & CTL_MASK));

  a_r3_rnd_sel: assert property (@(posedge clk) disable iff (!rst_run_n)
    rnd_zero_o == ctl_q_o[0]);

  a_r5_bank_dst: assert property (@(posedge clk) disable iff (!rst_run_n)
    $past(rst_run_n) && dec_fr_we_o |-> dec_dst_o[4] == $past(ctl_q_o[BANK_BIT]));

  a_r6_dbl_even: assert property (@(posedge clk) disable iff (!rst_run_n)
    dec_dbl_o && dec_fr_we_o |-> !dec_dst_o[0]);

  a_r7_ftoi_even: assert property (@(posedge clk) disable iff (!rst_run_n)
    dec_dbl_o && dec_ful_we_o |-> !dec_src_a_o[0]);

  a_r10_mode_sampled: assert property (@(posedge clk) disable iff (!rst_run_n)
    $past(rst_run_n) && dec_op_o != 4'd0 |-> dec_dbl_o == $past(ctl_q_o[PREC_BIT]));

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_run_n)
    dec_illegal_o |-> !dec_fr_we_o && !dec_ful_we_o && dec_op_o == 4'd0);

  a_r9_one_effect: assert property (@(posedge clk) disable iff (!rst_run_n)
    $onehot0({dec_fr_we_o, dec_ful_we_o, dec_illegal_o}));

  a_r8_imm_only_ld1: assert property (@(posedge clk) disable iff (!rst_run_n)
    dec_imm_o != 32'h0 |-> dec_op_o == 4'd8 && !dec_dbl_o);
endmodule

bind fpu_op_decoder fpu_op_decoder_chk #(
  .CTL_MASK(CTL_MASK), .PREC_BIT(PREC_BIT), .BANK_BIT(BANK_BIT)
) chk_i (
  .clk          (clk),
  .rst_run_n    (rst_run_n),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .ctl_q_o      (ctl_q_o),
  .rnd_zero_o   (rnd_zero_o),
  .dec_op_o     (dec_op_o),
  .dec_dbl_o    (dec_dbl_o),
  .dec_src_a_o  (dec_src_a_o),
  .dec_dst_o    (dec_dst_o),
  .dec_fr_we_o  (dec_fr_we_o),
  .dec_ful_we_o (dec_ful_we_o),
  .dec_illegal_o(dec_illegal_o),
  .dec_imm_o    (dec_imm_o)
);

// File: tb/fpu_op_decoder_tb_top.sv
module fpu_op_decoder_tb_top;
  import fpu_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] insn = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_q;
  logic        rnd_zero;
  logic [3:0]  d_op;
  logic        d_dbl, d_frwe, d_fulwe, d_ill;
  logic [4:0]  d_sa, d_sb, d_dst;
  logic [31:0] d_imm;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] model_ctl = 32'h0004_0001;

  always #4 clk = ~clk;

  fpu_op_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .ctl_wr_i(ctl_wr),
    .ctl_wdata_i(ctl_wdata), .ctl_q_o(ctl_q), .rnd_zero_o(rnd_zero),
    .dec_op_o(d_op), .dec_dbl_o(d_dbl), .dec_src_a_o(d_sa),
    .dec_src_b_o(d_sb), .dec_dst_o(d_dst), .dec_fr_we_o(d_frwe),
    .dec_ful_we_o(d_fulwe), .dec_illegal_o(d_ill), .dec_imm_o(d_imm)
  );

  function automatic fdec_t ref_dec(input logic [15:0] w, input logic [31:0] c);
    fdec_t r;
    logic  pr;
    logic [4:0] rn, rm;
    r  = '0;
    pr = c[19];
    rn = {1'b0, w[11:8]} ^ (c[21] ? 5'h10 : 5'h00);
    rm = {1'b0, w[7:4]}  ^ (c[21] ? 5'h10 : 5'h00);
    if (w[15:12] != 4'hF) return r;
    if ((w & 16'hF00F) inside {16'hF000, 16'hF001, 16'hF002, 16'hF003}) begin
      if (pr && (w & 16'h0110) != 0) begin r.illegal = 1'b1; return r; end
      case (w[1:0])
        2'd0: r.op = FOP_ADD;
        2'd1: r.op = FOP_SUB;
        2'd2: r.op = FOP_MUL;
        default: r.op = FOP_DIV;
      endcase
      r.dbl = pr; r.src_a = rn; r.src_b = rm; r.dst = rn; r.fr_we = 1'b1;
    end else if ((w & 16'hF0FF) == 16'hF02D) begin
      if (pr && w[8]) r.illegal = 1'b1;
      else begin r.op = FOP_ITOF; r.dbl = pr; r.dst = rn; r.fr_we = 1'b1; end
    end else if ((w & 16'hF0FF) == 16'hF03D) begin
      if (pr && w[8]) r.illegal = 1'b1;
      else begin r.op = FOP_FTOI; r.dbl = pr; r.src_a = rn; r.ful_we = 1'b1; end
    end else if ((w & 16'hF0FF) == 16'hF08D || (w & 16'hF0FF) == 16'hF09D) begin
      if (pr) r.illegal = 1'b1;
      else begin
        r.op    = (w[7:4] == 4'h9) ? FOP_LD1 : FOP_LD0;
        r.imm   = (w[7:4] == 4'h9) ? 32'h3F80_0000 : 32'h0;
        r.dst   = rn;
        r.fr_we = 1'b1;
      end
    end else begin
      r.illegal = 1'b1;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    if (w[15:12] != 4'hF) return "R9";
    if (w[3:2] == 2'b00) return "R4";
    if (w[7:0] == 8'h2D || w[7:0] == 8'h3D) return "R7";
    if (w[7:0] == 8'h8D || w[7:0] == 8'h9D) return "R8";
    return "R9";
  endfunction

  // called at a falling edge: drives, waits one cycle, compares
  task automatic apply(input logic [15:0] w, input logic wr,
                       input logic [31:0] wd, input string tag);
    fdec_t exp_d, act_d;
    logic [31:0] exp_ctl;
    insn = w; ctl_wr = wr; ctl_wdata = wd;
    exp_d = ref_dec(w, model_ctl);
    if (wr) model_ctl = wd & 32'h003F_FFFF;
    exp_ctl = model_ctl;
    @(negedge clk);
    act_d = {d_op, d_dbl, d_sa, d_sb, d_dst, d_frwe, d_fulwe, d_ill, d_imm};
    n_chk++;
    if (act_d !== exp_d || ctl_q !== exp_ctl || rnd_zero !== exp_ctl[0]) begin
      n_bad++;
      $display("FAIL %s insn=%h dec act=%h exp=%h ctl act=%h exp=%h rnd act=%b exp=%b",
               tag, w, act_d, exp_d, ctl_q, exp_ctl, rnd_zero, exp_ctl[0]);
    end
  endtask

  task automatic check_reset(input string tag);
    n_chk++;
    if (ctl_q !== 32'h0004_0001 || rnd_zero !== 1'b1 || d_op !== 4'd0 ||
        d_frwe !== 1'b0 || d_fulwe !== 1'b0 || d_ill !== 1'b0 ||
        d_dst !== 5'd0 || d_imm !== 32'd0) begin
      n_bad++;
      $display("FAIL %s reset ctl act=%h exp=00040001 rnd act=%b exp=1 op act=%h exp=0 ill act=%b exp=0",
               tag, ctl_q, rnd_zero, d_op, d_ill);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset("R1");

    // single, bank 0
    apply(16'hF350, 1'b0, '0, "R4");
    apply(16'hF351, 1'b0, '0, "R4");
    apply(16'hFA72, 1'b0, '0, "R4");
    apply(16'hF1E3, 1'b0, '0, "R4");
    apply(16'hF42D, 1'b0, '0, "R7");
    apply(16'hF53D, 1'b0, '0, "R7");
    apply(16'hF68D, 1'b0, '0, "R8");
    apply(16'hF79D, 1'b0, '0, "R8");
    apply(16'hF004, 1'b0, '0, "R9");
    apply(16'hFFFF, 1'b0, '0, "R9");
    apply(16'h1234, 1'b0, '0, "R9");
    // all-ones write: mask, bank, double, nearest-even clear via bit0=1
    apply(16'h0000, 1'b1, 32'hFFFF_FFFF, "R2");
    apply(16'hF240, 1'b0, '0, "R5");
    apply(16'hF100, 1'b0, '0, "R6");
    apply(16'hF010, 1'b0, '0, "R6");
    apply(16'hF12D, 1'b0, '0, "R7");
    apply(16'hF23D, 1'b0, '0, "R7");
    apply(16'hF08D, 1'b0, '0, "R8");
    apply(16'hF09D, 1'b0, '0, "R8");
    apply(16'hF0A0, 1'b0, '0, "R11");
    // round to nearest even, bank 1, single
    apply(16'h0000, 1'b1, 32'h0020_0000, "R3");
    apply(16'hF9C1, 1'b0, '0, "R5");
    // same-cycle mode write does not affect this opcode
    apply(16'hF101, 1'b1, 32'h0008_0000, "R10");
    apply(16'hF101, 1'b0, '0, "R10");
    apply(16'hF09D, 1'b1, 32'h0000_0001, "R10");
    apply(16'hF09D, 1'b0, '0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      logic [31:0] r;
      logic        wr;
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1, 3'd2: w = {4'hF, r[11:4], 2'b00, r[13:12]};
        3'd3: begin
          case (r[15:14])
            2'd0: w = {4'hF, r[7:4], 8'h2D};
            2'd1: w = {4'hF, r[7:4], 8'h3D};
            2'd2: w = {4'hF, r[7:4], 8'h8D};
            default: w = {4'hF, r[7:4], 8'h9D};
          endcase
        end
        3'd4, 3'd5: w = {4'hF, r[27:16]};
        default: w = r[31:16];
      endcase
      wr = ($urandom % 8) == 0;
      apply(w, wr, $urandom, wr ? "R2" : tag_of(w));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule